// File: doc/BRIEF.md
# Per-Core Idle Power-Down Sequencer

This block sequences idle entry for a group of processor cores. Each core owns a small register bank. Software writes request bits, wait conditions, wakeup enables and interrupt masks into it. A per-core state machine then watches that core's wait-for-interrupt line and the snoop-queue-empty indication, and carries out one of two transitions. The first is a power-down, which ends in the OFF state. The second is a clock-frequency change, which takes a fixed number of cycles and then reports a completion event. The power switch, the clock generator and the cache are outside the block. They appear only as the state-machine outputs and as fixed latencies.

Each sequencer has seven states: IDLE, WAIT_WFI, WAIT_SNOOP, POWER_DOWN, DFS_CHANGE, OFF and WAKE. The transitions are as follows:

- **IDLE to WAIT_WFI:** a request arrives with the WFI wait enabled.
- **Bypass when the WFI wait is clear:** the machine goes straight on to the next step.
- **Next step for a power-down request:** WAIT_SNOOP when the snoop wait is enabled, otherwise POWER_DOWN.
- **Next step for a frequency request:** DFS_CHANGE.
- **Abort:** WAIT_WFI or WAIT_SNOOP returns to IDLE when the request is withdrawn.
- **WAIT_SNOOP to POWER_DOWN:** the snoop queue becomes empty.
- **POWER_DOWN to OFF:** the programmed delay has elapsed.
- **DFS_CHANGE to IDLE:** the change latency has elapsed.
- **OFF to WAKE:** an enabled wakeup source is active.
- **WAKE to IDLE:** always, after one cycle.

A shared fabric-level output signals that L2 and the fabric may power down. It is raised only when every core is off and at least one of them asked for it.

Top module: `idle_pwr_ctrl`

## Requirements

Address map: bank 0 holds the global registers, and core c uses bank c+1. The bank is selected by address bits 11:8, and the register by the offset in bits 7:0. Writing a register stores the listed fields. Reading it returns those fields at the same positions, with every other bit reading as zero.

| Register | Location | Fields |
|---|---|---|
| Fabric enable | global, offset 0x04 | bit 0 |
| Power-down delay | global, offset 0x08 | bits 15:0 |
| Request | core bank, offset 0x00 | bit 0 power-down, bit 1 frequency change, bit 2 L2 power-down |
| Snoop skip | core bank, offset 0x04 | bit 0 skips the hardware snoop-disable step |
| Configuration | core bank, offset 0x08 | bit 0 wait for WFI, bit 1 wait for snoop-empty, bit 4 IRQ wake enable, bit 5 FIQ wake enable, bit 6 debug wake enable, bit 8 IRQ mask, bit 9 FIQ mask |
| Event | core bank, offset 0x0C | bit 0 change-done, bit 8 done-interrupt mask |
| Restart address | core bank, offset 0x10 | bits 31:0 |

- R1: After reset no core is off, the delay register reads 0x64, and every core register reads 0.
- R2: `irq_to_core` and `fiq_to_core` follow `irq_in` and `fiq_in` unless configuration bit 8 (IRQ) or bit 9 (FIQ) of that core is set, in which case they are held low.
- R3: With the WFI wait set, a request does not progress while `core_wfi` is low. Clearing the request before WFI returns the core to IDLE, and it never powers down.
- R4: With the snoop wait set, a power-down sequence holds in WAIT_SNOOP until `snoop_empty` is high.
- R5: A wait whose bit is clear is bypassed. POWER_DOWN lasts delay+1 cycles, after which `core_pwr_off` rises.
- R6: `snoop_dis` is high throughout POWER_DOWN unless snoop-skip bit 0 is set.
- R7: In OFF, a wakeup source whose enable bit is set moves the core to WAKE. A source that is not enabled leaves the core off.
- R8: WAKE lasts one cycle. In that cycle `core_rst_release` pulses and `restart_addr` carries the restart-address register. The hardware then clears request bit 0.
- R9: A frequency request, once WFI is satisfied, runs DFS_CHANGE for DFS_LAT cycles without powering the core off. It then sets event bit 0 and clears request bit 1.
- R10: Writing event bit 0 as zero clears it. `dfs_irq` equals event bit 0 AND NOT event bit 8.
- R11: `l2_pwr_off` is high only when fabric-enable bit 0 is set, all cores are off, and at least one core that is off has request bit 2 set.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register address (bank in 11:8, offset in 7:0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_wfi | input | NCORES | Per-core wait-for-interrupt indication |
| snoop_empty | input | NCORES | Per-core snoop-queue-empty indication |
| irq_in | input | NCORES | Per-core IRQ from the interrupt controller |
| fiq_in | input | NCORES | Per-core FIQ from the interrupt controller |
| dbg_in | input | NCORES | Per-core debug wake request |
| irq_to_core | output | NCORES | IRQ after masking |
| fiq_to_core | output | NCORES | FIQ after masking |
| snoop_dis | output | NCORES | Hardware snoop-disable step active |
| core_pwr_off | output | NCORES | Core is in OFF |
| core_rst_release | output | NCORES | One-cycle reset-release pulse in WAKE |
| restart_addr | output | 32*NCORES | Restart address per core, valid with the pulse |
| dfs_irq | output | NCORES | Unmasked frequency-change-done interrupt |
| l2_pwr_off | output | 1 | L2 and fabric may power down |

## Verification

The bound checker watches several relationships on every cycle:

- the snoop-disable step never overlaps OFF;
- the reset-release pulse is a single cycle and only ever follows OFF;
- leaving OFF always produces that pulse;
- the L2 output implies that every core is off;
- a forwarded interrupt is always backed by its source.

Other behaviour can only be shown by the bench's scenarios:

- the exact length of POWER_DOWN and DFS_CHANGE;
- the abort before WFI;
- which wakeup source and enable pairs succeed;
- the hardware clearing of request bits;
- the completion event with its software clear and its mask.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_WFI,
        ST_WAIT_SNOOP,
        ST_POWER_DOWN,
        ST_DFS_CHANGE,
        ST_OFF,
        ST_WAKE
    } seq_state_t;

    typedef struct packed {
        logic        pd_req;
        logic        dfs_req;
        logic        l2_req;
        logic        skip_snoop;
        logic        wait_wfi;
        logic        wait_snoop;
        logic        irq_en;
        logic        fiq_en;
        logic        dbg_en;
        logic        irq_mask;
        logic        fiq_mask;
        logic        done_mask;
        logic [31:0] boot;
    } core_cfg_t;

    localparam logic [7:0] OFS_REQ   = 8'h00;
    localparam logic [7:0] OFS_SKIP  = 8'h04;
    localparam logic [7:0] OFS_CFG   = 8'h08;
    localparam logic [7:0] OFS_EVT   = 8'h0C;
    localparam logic [7:0] OFS_BOOT  = 8'h10;
    localparam logic [7:0] OFS_FAB   = 8'h04;
    localparam logic [7:0] OFS_DELAY = 8'h08;

endpackage

// File: rtl/core_regs.sv
module core_regs
    import ipc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  ofs,
    input  logic [31:0] wdata,
    input  logic        hw_pd_clr,
    input  logic        hw_dfs_clr,
    input  logic        hw_done_set,
    output core_cfg_t   cfg,
    output logic        done,
    output logic [31:0] rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg  <= '0;
            done <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (ofs)
                    OFS_REQ: begin
                        cfg.pd_req  <= wdata[0];
                        cfg.dfs_req <= wdata[1];
                        cfg.l2_req  <= wdata[2];
                    end
                    OFS_SKIP: cfg.skip_snoop <= wdata[0];
                    OFS_CFG: begin
                        cfg.wait_wfi   <= wdata[0];
                        cfg.wait_snoop <= wdata[1];
                        cfg.irq_en     <= wdata[4];
                        cfg.fiq_en     <= wdata[5];
                        cfg.dbg_en     <= wdata[6];
                        cfg.irq_mask   <= wdata[8];
                        cfg.fiq_mask   <= wdata[9];
                    end
                    OFS_EVT: begin
                        done          <= wdata[0];
                        cfg.done_mask <= wdata[8];
                    end
                    OFS_BOOT: cfg.boot <= wdata;
                    default: ;
                endcase
            end
            if (hw_pd_clr)   cfg.pd_req  <= 1'b0;
            if (hw_dfs_clr)  cfg.dfs_req <= 1'b0;
            if (hw_done_set) done        <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (ofs)
            OFS_REQ:  rdata[2:0] = {cfg.l2_req, cfg.dfs_req, cfg.pd_req};
            OFS_SKIP: rdata[0]   = cfg.skip_snoop;
            OFS_CFG: begin
                rdata[1:0] = {cfg.wait_snoop, cfg.wait_wfi};
                rdata[6:4] = {cfg.dbg_en, cfg.fiq_en, cfg.irq_en};
                rdata[9:8] = {cfg.fiq_mask, cfg.irq_mask};
            end
            OFS_EVT: begin
                rdata[0] = done;
                rdata[8] = cfg.done_mask;
            end
            OFS_BOOT: rdata = cfg.boot;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/core_seq.sv
module core_seq
    import ipc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DFS_LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  core_cfg_t        cfg,
    input  logic [CNT_W-1:0] delay,
    input  logic             wfi,
    input  logic             snoop_empty,
    input  logic             irq,
    input  logic             fiq,
    input  logic             dbg,
    output logic             pd_clr,
    output logic             dfs_clr,
    output logic             done_set,
    output logic             pwr_off,
    output logic             rst_release,
    output logic             snoop_dis,
    output logic [31:0]      restart_addr
);

    localparam logic [CNT_W-1:0] DFS_LAST = CNT_W'(DFS_LAT - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             req_any, wake_hit;
    seq_state_t       after_wfi;

    assign req_any  = cfg.pd_req | cfg.dfs_req;
    assign wake_hit = (irq & cfg.irq_en) | (fiq & cfg.fiq_en) | (dbg & cfg.dbg_en);

    always_comb begin
        if (cfg.pd_req)
            after_wfi = cfg.wait_snoop ? ST_WAIT_SNOOP : ST_POWER_DOWN;
        else
            after_wfi = ST_DFS_CHANGE;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (req_any) nxt = cfg.wait_wfi ? ST_WAIT_WFI : after_wfi;
            ST_WAIT_WFI:
                if (!req_any)  nxt = ST_IDLE;
                else if (wfi)  nxt = after_wfi;
            ST_WAIT_SNOOP:
                if (!cfg.pd_req)     nxt = ST_IDLE;
                else if (snoop_empty) nxt = ST_POWER_DOWN;
            ST_POWER_DOWN:
                if (cnt >= delay) nxt = ST_OFF;
            ST_DFS_CHANGE:
                if (cnt >= DFS_LAST) nxt = ST_IDLE;
            ST_OFF:
                if (wake_hit) nxt = ST_WAKE;
            ST_WAKE:
                nxt = ST_IDLE;
            default:
                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                cnt <= '0;
            else if (state == ST_POWER_DOWN || state == ST_DFS_CHANGE)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        pd_clr       = 1'b0;
        dfs_clr      = 1'b0;
        done_set     = 1'b0;
        pwr_off      = 1'b0;
        rst_release  = 1'b0;
        snoop_dis    = 1'b0;
        restart_addr = '0;
        unique case (state)
            ST_POWER_DOWN: snoop_dis = ~cfg.skip_snoop;
            ST_DFS_CHANGE: begin
                done_set = (cnt >= DFS_LAST);
                dfs_clr  = (cnt >= DFS_LAST);
            end
            ST_OFF: pwr_off = 1'b1;
            ST_WAKE: begin
                rst_release  = 1'b1;
                restart_addr = cfg.boot;
                pd_clr       = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
    import ipc_pkg::*;
#(
    parameter int          NCORES    = 2,
    parameter int          CNT_W     = 16,
    parameter int          DFS_LAT   = 4,
    parameter logic [15:0] DELAY_RST = 16'h0064
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NCORES-1:0]    core_wfi,
    input  logic [NCORES-1:0]    snoop_empty,
    input  logic [NCORES-1:0]    irq_in,
    input  logic [NCORES-1:0]    fiq_in,
    input  logic [NCORES-1:0]    dbg_in,
    output logic [NCORES-1:0]    irq_to_core,
    output logic [NCORES-1:0]    fiq_to_core,
    output logic [NCORES-1:0]    snoop_dis,
    output logic [NCORES-1:0]    core_pwr_off,
    output logic [NCORES-1:0]    core_rst_release,
    output logic [32*NCORES-1:0] restart_addr,
    output logic [NCORES-1:0]    dfs_irq,
    output logic                 l2_pwr_off
);

    logic [3:0]       bank;
    logic [7:0]       ofs;
    logic             fab_en;
    logic [CNT_W-1:0] delay;
    logic [31:0]      glb_rdata;
    logic [31:0]      core_rdata [NCORES];
    logic [NCORES-1:0] l2_req_v;

    assign bank = bus_addr[11:8];
    assign ofs  = bus_addr[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fab_en <= 1'b0;
            delay  <= CNT_W'(DELAY_RST);
        end else if (bus_wr && bank == 4'd0) begin
            if (ofs == OFS_FAB)   fab_en <= bus_wdata[0];
            if (ofs == OFS_DELAY) delay  <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        glb_rdata = '0;
        if (ofs == OFS_FAB)   glb_rdata[0]         = fab_en;
        if (ofs == OFS_DELAY) glb_rdata[CNT_W-1:0] = delay;
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        core_cfg_t cfg;
        logic      done, pd_clr, dfs_clr, done_set;

        core_regs u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (bus_wr && bank == 4'(c + 1)),
            .ofs         (ofs),
            .wdata       (bus_wdata),
            .hw_pd_clr   (pd_clr),
            .hw_dfs_clr  (dfs_clr),
            .hw_done_set (done_set),
            .cfg         (cfg),
            .done        (done),
            .rdata       (core_rdata[c])
        );

        core_seq #(.CNT_W(CNT_W), .DFS_LAT(DFS_LAT)) u_seq (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg          (cfg),
            .delay        (delay),
            .wfi          (core_wfi[c]),
            .snoop_empty  (snoop_empty[c]),
            .irq          (irq_in[c]),
            .fiq          (fiq_in[c]),
            .dbg          (dbg_in[c]),
            .pd_clr       (pd_clr),
            .dfs_clr      (dfs_clr),
            .done_set     (done_set),
            .pwr_off      (core_pwr_off[c]),
            .rst_release  (core_rst_release[c]),
            .snoop_dis    (snoop_dis[c]),
            .restart_addr (restart_addr[32*c +: 32])
        );

        assign irq_to_core[c] = irq_in[c] & ~cfg.irq_mask;
        assign fiq_to_core[c] = fiq_in[c] & ~cfg.fiq_mask;
        assign dfs_irq[c]     = done & ~cfg.done_mask;
        assign l2_req_v[c]    = cfg.l2_req;
    end

    always_comb begin
        bus_rdata = '0;
        if (bank == 4'd0)
            bus_rdata = glb_rdata;
        for (int c = 0; c < NCORES; c++)
            if (bank == 4'(c + 1))
                bus_rdata = core_rdata[c];
    end

    assign l2_pwr_off = fab_en & (&core_pwr_off) & (|(l2_req_v & core_pwr_off));

endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk #(
    parameter int NCORES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCORES-1:0] irq_in,
    input logic [NCORES-1:0] fiq_in,
    input logic [NCORES-1:0] irq_to_core,
    input logic [NCORES-1:0] fiq_to_core,
    input logic [NCORES-1:0] snoop_dis,
    input logic [NCORES-1:0] core_pwr_off,
    input logic [NCORES-1:0] core_rst_release,
    input logic              l2_pwr_off
);

    for (genvar c = 0; c < NCORES; c++) begin : g_chk
        // R6
        snoop_not_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            snoop_dis[c] |-> !core_pwr_off[c]);

        // R8
        release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            core_rst_release[c] |=> !core_rst_release[c]);

        // R8
        release_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            core_rst_release[c] |-> $past(core_pwr_off[c]));

        // R7
        leave_off_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_pwr_off[c]) |-> core_rst_release[c]);

        // R2
        irq_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_to_core[c] |-> irq_in[c]);

        // R2
        fiq_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fiq_to_core[c] |-> fiq_in[c]);
    end

    // R11
    l2_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_pwr_off |-> &core_pwr_off);

endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk #(.NCORES(NCORES)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .irq_in           (irq_in),
    .fiq_in           (fiq_in),
    .irq_to_core      (irq_to_core),
    .fiq_to_core      (fiq_to_core),
    .snoop_dis        (snoop_dis),
    .core_pwr_off     (core_pwr_off),
    .core_rst_release (core_rst_release),
    .l2_pwr_off       (l2_pwr_off)
);

// File: tb/idle_pwr_ctrl_tb.sv
module idle_pwr_ctrl_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          NC         = 2;
    localparam int          LAT        = 4;
    localparam logic [11:0] C0         = 12'h100;
    localparam logic [11:0] C1         = 12'h200;

    // {expect_wake, src(dbg,fiq,irq), en(dbg,fiq,irq)}
    localparam logic [6:0] WAKE_TBL [6] = '{
        7'b1_001_001, 7'b0_001_010, 7'b1_010_010,
        7'b1_100_100, 7'b0_100_011, 7'b0_010_001
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     core_wfi = '0, snoop_empty = '0;
    logic [NC-1:0]     irq_in = '0, fiq_in = '0, dbg_in = '0;
    logic [NC-1:0]     irq_to_core, fiq_to_core, snoop_dis, core_pwr_off;
    logic [NC-1:0]     core_rst_release, dfs_irq;
    logic [32*NC-1:0]  restart_addr;
    logic              l2_pwr_off;

    int  n_tests = 0;
    int  n_fail  = 0;
    logic finished = 1'b0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_pwr_ctrl #(.NCORES(NC), .DFS_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_wfi(core_wfi),
        .snoop_empty(snoop_empty), .irq_in(irq_in), .fiq_in(fiq_in),
        .dbg_in(dbg_in), .irq_to_core(irq_to_core), .fiq_to_core(fiq_to_core),
        .snoop_dis(snoop_dis), .core_pwr_off(core_pwr_off),
        .core_rst_release(core_rst_release), .restart_addr(restart_addr),
        .dfs_irq(dfs_irq), .l2_pwr_off(l2_pwr_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        core_wfi = '0; snoop_empty = '0; irq_in = '0; fiq_in = '0; dbg_in = '0;
        tick(3);
        rst_n = 1'b1;
        wr(12'h008, 32'd2);
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(12'h008, rv);             chk("R1 delay", rv, 32'h64);
        chk("R1 off", 32'(core_pwr_off), 32'h0);
        rd(C0 + 12'h008, rv);        chk("R1 cfg", rv, 32'h0);
        rd(C0 + 12'h000, rv);        chk("R1 req", rv, 32'h0);

        // R2 masking
        do_reset();
        irq_in = 2'b11; fiq_in = 2'b11;
        #1 chk("R2 irq pass", 32'(irq_to_core), 32'h3);
        wr(C0 + 12'h008, 32'h100);
        #1 chk("R2 irq mask", 32'(irq_to_core), 32'h2);
        chk("R2 fiq pass", 32'(fiq_to_core), 32'h3);
        wr(C0 + 12'h008, 32'h200);
        #1 chk("R2 fiq mask", 32'(fiq_to_core), 32'h2);
        chk("R2 irq unmask", 32'(irq_to_core), 32'h3);

        // R7 R8 wake table
        for (int e = 0; e < 6; e++) begin
            logic [6:0] t;
            t = WAKE_TBL[e];
            do_reset();
            core_wfi = 2'b01; snoop_empty = 2'b01;
            wr(C0 + 12'h010, 32'h8000_0000 + 32'(e));
            wr(C0 + 12'h008, 32'h3 | (32'(t[2:0]) << 4));
            wr(C0 + 12'h000, 32'h1);
            tick(8);
            chk("R7 reached off", 32'(core_pwr_off[0]), 32'h1);
            irq_in[0] = t[3]; fiq_in[0] = t[4]; dbg_in[0] = t[5];
            tick(1);
            if (t[6]) begin
                chk("R7 wake", 32'(core_rst_release[0]), 32'h1);
                chk("R8 restart addr", restart_addr[31:0], 32'h8000_0000 + 32'(e));
                tick(1);
                chk("R8 single pulse", 32'(core_rst_release[0]), 32'h0);
            end else begin
                tick(2);
                chk("R7 no wake off", 32'(core_pwr_off[0]), 32'h1);
                chk("R7 no wake pulse", 32'(core_rst_release[0]), 32'h0);
                wr(C0 + 12'h008, 32'h73);
            end
            tick(3);
            irq_in = '0; fiq_in = '0; dbg_in = '0;
            chk("R8 back on", 32'(core_pwr_off[0]), 32'h0);
            rd(C0 + 12'h000, rv);  chk("R8 req cleared", rv, 32'h0);
        end

        // R3 abort before WFI
        do_reset();
        snoop_empty = 2'b01;
        wr(C0 + 12'h008, 32'h1);
        wr(C0 + 12'h000, 32'h1);
        tick(5);
        chk("R3 waits for wfi", 32'(core_pwr_off[0] | snoop_dis[0]), 32'h0);
        wr(C0 + 12'h000, 32'h0);
        tick(2);
        core_wfi = 2'b01;
        tick(10);
        chk("R3 aborted no off", 32'(core_pwr_off[0]), 32'h0);
        chk("R3 aborted no snoop step", 32'(snoop_dis[0]), 32'h0);

        // R4 R5 R6 snoop wait and delay length
        do_reset();
        core_wfi = 2'b01;
        wr(C0 + 12'h008, 32'h3);
        wr(C0 + 12'h000, 32'h1);
        tick(10);
        chk("R4 held for snoop", 32'(core_pwr_off[0] | snoop_dis[0]), 32'h0);
        snoop_empty = 2'b01;
        tick(1);
        chk("R6 snoop step", 32'(snoop_dis[0]), 32'h1);
        tick(2);
        chk("R5 still powering down", 32'(core_pwr_off[0]), 32'h0);
        tick(1);
        chk("R5 off after delay+1", 32'(core_pwr_off[0]), 32'h1);

        // R5 R6 bypass and skip
        do_reset();
        wr(C0 + 12'h004, 32'h1);
        wr(C0 + 12'h000, 32'h1);
        tick(1);
        chk("R6 skip snoop step", 32'(snoop_dis[0]), 32'h0);
        chk("R5 bypass not yet off", 32'(core_pwr_off[0]), 32'h0);
        tick(3);
        chk("R5 bypass off", 32'(core_pwr_off[0]), 32'h1);

        // R9 R10 frequency change
        do_reset();
        wr(C0 + 12'h008, 32'h1);
        wr(C0 + 12'h000, 32'h2);
        tick(4);
        rd(C0 + 12'h00C, rv);  chk("R9 waits for wfi", rv, 32'h0);
        core_wfi = 2'b01;
        tick(LAT);
        rd(C0 + 12'h00C, rv);  chk("R9 not done early", rv, 32'h0);
        tick(1);
        rd(C0 + 12'h00C, rv);  chk("R9 done", rv, 32'h1);
        chk("R9 never off", 32'(core_pwr_off[0]), 32'h0);
        rd(C0 + 12'h000, rv);  chk("R9 req cleared", rv, 32'h0);
        chk("R10 irq", 32'(dfs_irq[0]), 32'h1);
        wr(C0 + 12'h00C, 32'h101);
        #1 chk("R10 irq masked", 32'(dfs_irq[0]), 32'h0);
        wr(C0 + 12'h00C, 32'h0);
        rd(C0 + 12'h00C, rv);  chk("R10 sw clear", rv, 32'h0);

        // R11 L2 power-down
        do_reset();
        wr(12'h004, 32'h1);
        wr(C0 + 12'h000, 32'h5);
        tick(5);
        chk("R11 one core off", 32'(l2_pwr_off), 32'h0);
        wr(C1 + 12'h000, 32'h1);
        tick(6);
        chk("R11 all off", 32'(l2_pwr_off), 32'h1);
        wr(12'h004, 32'h0);
        #1 chk("R11 fabric disabled", 32'(l2_pwr_off), 32'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule